// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregator

This block gathers up to thirty-two interrupt sources onto a single active-high request line for a processor. The low sixteen sources are internal event strobes, always active-high and edge-sensitive. Up to sixteen further sources, placed from bit 16 upward, are external lines whose active level and trigger style are fixed per source by parameters at elaboration. Every source first passes through a polarity stage that makes it active-high. Edge-sensitive sources then latch a status bit on a rising edge of that normalised signal. Level-sensitive sources latch it on every cycle in which the signal is high.

Software sees four 32-bit word registers on a plain register bus: status, pending, enable and acknowledge. Pending is status masked by enable, and the request line is high while any pending bit is set. Writing ones to the acknowledge register drops the matching status bits. A level source that is still active sets its bit again in the same step, so the line stays up until the cause is removed.

The register bus has no back-pressure. A write is taken on the rising clock edge in which select and write are both high. Read data is a combinational function of the address, so it is valid in the same cycle. No stream interface exists here, so there is no valid/ready handshake.

Top module: `irq_gather`

## Requirements
- R1: After reset the status, pending and enable registers read zero and `irq_out` is low.
- R2: A source whose polarity parameter bit is 0 is active-low: raw 0 is its active level. A 1 means active-high. Sources 0 to 15 are always active-high.
- R3: An edge source (trigger parameter bit 1) sets its status bit only on the clock edge after its normalised input goes from 0 to 1. Holding the input active does not set the bit again after an acknowledge.
- R4: A level source (trigger parameter bit 0) sets its status bit on every clock edge at which its normalised input is high. The bit stays set after the input drops, until it is acknowledged.
- R5: Sources 0 to 15 are always edge-triggered. External source k sits at status bit 16+k and takes bit k of each configuration parameter.
- R6: The pending register (offset 0x34) always reads status AND enable.
- R7: `irq_out` is high exactly when the pending value is nonzero.
- R8: A write to the acknowledge register (offset 0x3C) clears the status bits written as 1. Bits written as 0 keep their value. Status bits never clear any other way except reset.
- R9: Status (0x30) and pending (0x34) are read-only, and writes to them have no effect. Enable (0x38) is read/write. Acknowledge (0x3C) and every unmapped address read as zero.
- R10: An input already active while reset is held produces no edge event once reset is released.
- R11: If an acknowledge of a bit coincides with a new event on that source, the bit stays set.
- R12: Status and enable bits at positions of unpopulated sources (16+N_EXT and up) always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 16+N_EXT | Raw interrupt sources, bit 0 upward; external sources from bit 16 |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 1 | Aggregated interrupt request, active high |

## Verification
Some rules are checked on every cycle against an independent model of the polarity stage. These are: a status bit clears only through an acknowledge, an edge source latches only on a rise, a level source that is high always latches, the request line follows status masked by enable, and unpopulated bit positions stay zero. Other behaviour shows only in the bench's scenarios. That covers the register map seen through reads, the quiet start when an input is active during reset, and the re-set of a level bit after an acknowledge. It also covers the collision of a new edge with its own acknowledge. The bench sweeps every source of a small mixed configuration through the same sequence and computes each expected register value from the configuration words.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  localparam logic [7:0] OFF_STATUS  = 8'h30;
  localparam logic [7:0] OFF_PENDING = 8'h34;
  localparam logic [7:0] OFF_ENABLE  = 8'h38;
  localparam logic [7:0] OFF_ACK     = 8'h3C;

  localparam int unsigned INT_SRCS = 16;
  localparam int unsigned MAX_EXT  = 16;

  // Bit mask of populated source positions.
  function automatic logic [31:0] src_mask(input int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int unsigned b = 0; b < 32; b++) begin
      if (b < n) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Internal sources always get 1; externals take their parameter bits.
  function automatic logic [31:0] cfg_word(input logic [15:0] ext, input int unsigned n);
    return {ext, 16'hFFFF} & src_mask(n);
  endfunction

endpackage

// File: rtl/irqg_front.sv
module irqg_front #(
  parameter int unsigned NSRC     = 32,
  parameter logic [31:0] POS_CFG  = 32'hFFFF_FFFF,
  parameter logic [31:0] EDGE_CFG = 32'hFFFF_FFFF
) (
  input  logic            clk,
  input  logic [NSRC-1:0] src_in,
  output logic [31:0]     event_o
);

  for (genvar g = 0; g < 32; g++) begin : g_src
    if (g < NSRC) begin : g_live
      logic norm;
      logic prev_q;

      assign norm = src_in[g] ^ ~POS_CFG[g];

      // Tracks the input even in reset, so a line held active through
      // reset gives no edge afterwards.
      always_ff @(posedge clk) begin
        prev_q <= norm;
      end

      if (EDGE_CFG[g]) begin : g_edge
        assign event_o[g] = norm & ~prev_q;
      end else begin : g_level
        assign event_o[g] = norm;
      end
    end else begin : g_empty
      assign event_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/irqg_status.sv
module irqg_status #(
  parameter logic [31:0] SRC_MASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] event_i,
  input  logic [31:0] ack_i,
  output logic [31:0] status_o
);

  logic [31:0] status_d;

  // A new event outranks an acknowledge of the same bit.
  assign status_d = ((status_o & ~ack_i) | event_i) & SRC_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= status_d;
  end

endmodule

// File: rtl/irqg_regif.sv
module irqg_regif #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] SRC_MASK = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       status_i,
  input  logic [31:0]       pending_i,
  output logic [31:0]       enable_o,
  output logic [31:0]       ack_o
);

  import irqg_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_PENDING = ADDR_W'(OFF_PENDING);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_ACK     = ADDR_W'(OFF_ACK);

  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_o <= '0;
    end else if (wr_en && bus_addr == A_ENABLE) begin
      enable_o <= bus_wdata & SRC_MASK;
    end
  end

  assign ack_o = (wr_en && bus_addr == A_ACK) ? (bus_wdata & SRC_MASK) : 32'd0;

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_addr == A_STATUS)       bus_rdata = status_i;
    else if (bus_addr == A_PENDING) bus_rdata = pending_i;
    else if (bus_addr == A_ENABLE)  bus_rdata = enable_o;
  end

endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int unsigned N_EXT        = 16,
  parameter logic [15:0] EXT_POSITIVE = 16'hFFFF,
  parameter logic [15:0] EXT_EDGE     = 16'h0000,
  parameter int unsigned ADDR_W       = 8,
  localparam int unsigned NSRC        = 16 + N_EXT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);

  import irqg_pkg::*;

  localparam logic [31:0] SRC_MASK = src_mask(NSRC);
  localparam logic [31:0] POS_CFG  = cfg_word(EXT_POSITIVE, NSRC);
  localparam logic [31:0] EDGE_CFG = cfg_word(EXT_EDGE, NSRC);

  initial begin
    if (N_EXT > MAX_EXT) $error("irq_gather: N_EXT above 16");
  end

  logic [31:0] event_w;
  logic [31:0] ack_w;
  logic [31:0] status_q;
  logic [31:0] enable_q;
  logic [31:0] pending;

  irqg_front #(
    .NSRC    (NSRC),
    .POS_CFG (POS_CFG),
    .EDGE_CFG(EDGE_CFG)
  ) front_i (
    .clk    (clk),
    .src_in (src_in),
    .event_o(event_w)
  );

  irqg_status #(
    .SRC_MASK(SRC_MASK)
  ) status_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (event_w),
    .ack_i   (ack_w),
    .status_o(status_q)
  );

  irqg_regif #(
    .ADDR_W  (ADDR_W),
    .SRC_MASK(SRC_MASK)
  ) regif_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .status_i (status_q),
    .pending_i(pending),
    .enable_o (enable_q),
    .ack_o    (ack_w)
  );

  assign pending = status_q & enable_q;
  assign irq_out = |pending;

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int unsigned N_EXT        = 16,
  parameter logic [15:0] EXT_POSITIVE = 16'hFFFF,
  parameter logic [15:0] EXT_EDGE     = 16'h0000,
  parameter int unsigned ADDR_W       = 8,
  localparam int unsigned NSRC        = 16 + N_EXT
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_in,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq_out,
  input logic [31:0]       status_q,
  input logic [31:0]       enable_q
);

  import irqg_pkg::*;

  localparam logic [31:0] MASK = src_mask(NSRC);
  localparam logic [31:0] POS  = cfg_word(EXT_POSITIVE, NSRC);
  localparam logic [31:0] EDG  = cfg_word(EXT_EDGE, NSRC);
  localparam logic [31:0] LVL  = ~EDG & MASK;

  logic [31:0] norm_c;
  logic [31:0] prev_c;
  logic [31:0] ack_c;

  assign norm_c = (32'(src_in) ^ ~POS) & MASK;
  assign ack_c  = (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_ACK)) ? bus_wdata : 32'd0;

  always_ff @(posedge clk) prev_c <= norm_c;

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(ack_c)) == 32'd0)); // R8

  AST_EDGE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & EDG & ~($past(norm_c) & ~$past(prev_c))) == 32'd0)); // R3

  AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(norm_c) & LVL) & ~status_q) == 32'd0)); // R4

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((status_q & enable_q) != 32'd0)); // R7

  AST_IRQ_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) != 32'd0) |-> irq_out); // R7

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | enable_q) & ~MASK) == 32'd0); // R12

endmodule

bind irq_gather irq_gather_chk #(
  .N_EXT       (N_EXT),
  .EXT_POSITIVE(EXT_POSITIVE),
  .EXT_EDGE    (EXT_EDGE),
  .ADDR_W      (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_in   (src_in),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq_out  (irq_out),
  .status_q (status_q),
  .enable_q (enable_q)
);

// File: tb/irq_gather_tb_top.sv
module irq_gather_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int unsigned N_EXT = 4;
  localparam int unsigned NSRC  = 16 + N_EXT;
  localparam logic [15:0] EXT_POS  = 16'h0005; // 16,18 active-high; 17,19 active-low
  localparam logic [15:0] EXT_EDGE = 16'h0003; // 16,17 edge; 18,19 level
  localparam logic [31:0] MASK  = (32'd1 << NSRC) - 32'd1;
  localparam logic [31:0] POSV  = {EXT_POS, 16'hFFFF} & MASK;
  localparam logic [31:0] EDGEV = {EXT_EDGE, 16'hFFFF} & MASK;
  localparam logic [7:0] A_ST = 8'h30, A_PD = 8'h34, A_EN = 8'h38, A_AK = 8'h3C;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_in;
  logic            bus_sel = 1'b0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_addr = 8'h00;
  logic [31:0]     bus_wdata = 32'd0;
  logic [31:0]     bus_rdata;
  logic            irq_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  irq_gather #(
    .N_EXT(N_EXT), .EXT_POSITIVE(EXT_POS), .EXT_EDGE(EXT_EDGE), .ADDR_W(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Drives source i to its active or idle raw level, then lets one edge pass.
  task automatic drive_src(input int i, input bit active);
    @(negedge clk);
    src_in[i] = active ? POSV[i] : ~POSV[i];
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    // R10: edge sources 0 and 16 already active while reset is held.
    src_in = ~POSV[NSRC-1:0];
    src_in[0]  = 1'b1;
    src_in[16] = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(A_ST, rd); check("R10 no edge after reset", rd, 32'd0);
    bus_read(A_PD, rd); check("R1 pending reset", rd, 32'd0);
    bus_read(A_EN, rd); check("R1 enable reset", rd, 32'd0);
    check("R1 irq reset", {31'd0, irq_out}, 32'd0);
    src_in[0]  = 1'b0;
    src_in[16] = 1'b0;
    @(negedge clk);

    // R9 and R12: register map behaviour.
    bus_write(A_ST, 32'hFFFF_FFFF);
    bus_read(A_ST, rd); check("R9 status read-only", rd, 32'd0);
    bus_write(A_PD, 32'hFFFF_FFFF);
    bus_read(A_PD, rd); check("R9 pending read-only", rd, 32'd0);
    bus_write(A_EN, 32'hFFFF_FFFF);
    bus_read(A_EN, rd); check("R12 enable unpopulated bits", rd, MASK);
    bus_read(A_AK, rd); check("R9 ack reads zero", rd, 32'd0);
    bus_read(8'h40, rd); check("R9 unmapped reads zero", rd, 32'd0);

    // Sweep every source. R2: 17 and 19 are active-low. R5: 0..15 edge.
    for (int i = 0; i < int'(NSRC); i++) begin
      logic [31:0] b;
      string tg;
      b  = 32'd1 << i;
      tg = EDGEV[i] ? "R3" : "R4";
      bus_write(A_EN, b);
      bus_write(A_AK, 32'hFFFF_FFFF);
      bus_read(A_ST, rd); check($sformatf("R8 idle clear src%0d", i), rd, 32'd0);

      drive_src(i, 1'b1);
      bus_read(A_ST, rd);
      check($sformatf("%s R2 R5 status set src%0d", tg, i), rd, b);
      bus_read(A_PD, rd); check($sformatf("R6 pending src%0d", i), rd, b);
      check($sformatf("R7 irq high src%0d", i), {31'd0, irq_out}, 32'd1);

      bus_write(A_AK, b);
      bus_read(A_ST, rd);
      check($sformatf("%s ack while active src%0d", tg, i), rd, EDGEV[i] ? 32'd0 : b);

      drive_src(i, 1'b0);
      bus_read(A_ST, rd);
      check($sformatf("%s after release src%0d", tg, i), rd, EDGEV[i] ? 32'd0 : b);
      if (EDGEV[i]) begin
        drive_src(i, 1'b1);
        drive_src(i, 1'b0);
      end
      bus_write(A_AK, ~b);
      bus_read(A_ST, rd); check($sformatf("R8 zeros keep bit src%0d", i), rd, b);
      bus_write(A_AK, b);
      bus_read(A_ST, rd); check($sformatf("R8 ack clears src%0d", i), rd, 32'd0);
      check($sformatf("R7 irq low src%0d", i), {31'd0, irq_out}, 32'd0);

      bus_write(A_EN, 32'd0);
      drive_src(i, 1'b1);
      bus_read(A_ST, rd); check($sformatf("R6 masked status src%0d", i), rd, b);
      bus_read(A_PD, rd); check($sformatf("R6 masked pending src%0d", i), rd, 32'd0);
      check($sformatf("R7 masked irq src%0d", i), {31'd0, irq_out}, 32'd0);
      drive_src(i, 1'b0);
      bus_write(A_AK, 32'hFFFF_FFFF);
    end

    // R11: new edge on source 0 in the same cycle as its acknowledge.
    bus_write(A_EN, 32'd1);
    drive_src(0, 1'b1);
    drive_src(0, 1'b0);
    @(negedge clk);
    src_in[0] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_AK; bus_wdata = 32'd1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(A_ST, rd); check("R11 event beats ack", rd, 32'd1);
    check("R11 irq stays high", {31'd0, irq_out}, 32'd1);

    // R4: a second level source held active keeps re-latching across acks.
    src_in[0] = 1'b0;
    bus_write(A_AK, 32'hFFFF_FFFF);
    drive_src(19, 1'b1);
    bus_write(A_AK, 32'hFFFF_FFFF);
    bus_read(A_ST, rd); check("R4 level re-set after full ack", rd, 32'd1 << 19);
    drive_src(19, 1'b0);
    bus_write(A_AK, 32'hFFFF_FFFF);
    bus_read(A_ST, rd); check("R8 final clear", rd, 32'd0);

    finish_run();
  end

endmodule